// File: doc/BRIEF.md
# Serial Multiplexed-ADC Host Controller

This block is the host side of a three-wire link to an external 8-channel multiplexed 12-bit serial converter. The wires are a chip select, a serial clock and one data line that both ends share. A client offers a 4-bit channel word through a valid/ready handshake. The controller raises chip select and shifts the word out on the data line. It then drops chip select so the converter switches channels and starts sampling. The controller stops driving the data line, lets a programmable number of idle serial clocks pass, and skips one null bit. It then shifts in the 12-bit conversion result.

To end the exchange, the controller raises chip select again for one serial-clock period, which resets the converter. It then returns chip select low, presents the result and pulses a done strobe for one system clock. The serial clock is made from the system clock by a programmable divider. The data line is split at the ports into an output value, an output enable and an input value, so that a pad cell or a tri-state buffer can join them into one wire.

Top module: `mxadc_host`

## Requirements
- R1: While the controller drives the data line, its output value changes only at a falling edge of the serial clock (or at the start of an exchange, when the serial clock is low). It holds steady while the serial clock is high.
- R2: `req_ready` is high only when the controller is idle, and a request is taken only in that state. A `req_valid` asserted during an exchange starts nothing and does not change the channel word being sent.
- R3: The system clock edge that accepts a request raises `cs` and asserts `dat_oe`, with `sclk` low and `dat_o` carrying bit 3 of the channel word.
- R4: Exactly four rising serial-clock edges occur while `cs` is high, and they carry the channel word most-significant bit first. `cs` and `dat_oe` both fall at the falling edge that follows the fourth rising edge, before any further rising edge.
- R5: After `cs` falls, the controller does not drive the data line. It ignores the first IDLE_CLKS rising edges and the null bit on the next rising edge. On the 12 rising edges after that it samples the result, most-significant bit first, for a total of IDLE_CLKS+13 rising edges with `cs` low.
- R6: At the falling edge after the last result bit, `cs` rises and stays high for 2*HALF_DIV system clocks. It then falls, and in that same cycle `done` pulses high for exactly one system clock with `result` valid.
- R7: `result` changes only in the cycle in which `done` is high, and holds its value between exchanges.
- R8: `sclk` is low whenever the controller is idle, and during an exchange it has a period of 2*HALF_DIV system clocks, with the first rising edge HALF_DIV clocks after acceptance.
- R9: While `rst_n` is low, `cs`, `sclk`, `dat_oe` and `done` are low, `req_ready` is high and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| req_valid | input | 1 | Request for one conversion exchange |
| req_chan | input | ADDR_BITS | Channel word sent to the converter, most-significant bit first |
| req_ready | output | 1 | High while idle; a request is taken when valid and ready are both high |
| cs | output | 1 | Converter chip select, idle low |
| sclk | output | 1 | Serial clock, idle low |
| dat_o | output | 1 | Value driven onto the shared data line |
| dat_oe | output | 1 | Drive enable for the shared data line |
| dat_i | input | 1 | Value read from the shared data line |
| done | output | 1 | One-cycle strobe at the end of an exchange |
| result | output | RES_BITS | Last received conversion result |

## Verification
The bench builds the controller with HALF_DIV=2 and IDLE_CLKS=3. With these values each serial half period spans two system clocks, so a converter model sampled between system clock edges can tell the order of serial edges and chip-select edges. With three idle clocks, an off-by-one in the idle count or in the null-bit skip shifts a set junk or null bit into the result's most-significant position, which the all-zero result patterns expose.

// File: rtl/mxadc_pkg.sv
package mxadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_RECV = 2'd2,
    ST_END  = 2'd3
  } mx_state_e;
endpackage

// File: rtl/mxadc_clkdiv.sv
// Half-period tick generator for the serial clock.
module mxadc_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mxadc_txshift.sv
// Parallel-load shifter presenting its most-significant bit.
module mxadc_txshift #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] par,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] q_q, q_d;
  logic         en;

  always_comb begin
    en  = load | shift;
    q_d = q_q;
    if (load)       q_d = par;
    else if (shift) q_d = {q_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (en) q_q <= q_d;
  end

  assign msb = q_q[W-1];
endmodule

// File: rtl/mxadc_rxshift.sv
// Serial-in shifter collecting bits most-significant first.
module mxadc_rxshift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = {q_q[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_q <= '0;
    else if (shift) q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/mxadc_ctrl.sv
// Exchange sequencer: chip select, serial clock and line direction.
module mxadc_ctrl
  import mxadc_pkg::*;
#(
  parameter int ADDR_BITS = 4,
  parameter int RES_BITS  = 12,
  parameter int IDLE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req_valid,
  output logic req_ready,
  output logic run,
  output logic cs,
  output logic sclk,
  output logic oe,
  output logic done,
  output logic addr_load,
  output logic addr_shift,
  output logic res_shift,
  output logic capture
);
  localparam int RX_RISES = IDLE_CLKS + 1 + RES_BITS;
  localparam int CNT_TOP  = (RX_RISES > ADDR_BITS) ? RX_RISES : ADDR_BITS;
  localparam int CNW      = $clog2(CNT_TOP + 1);
  localparam logic [CNW-1:0] ADDR_LAST = CNW'(ADDR_BITS);
  localparam logic [CNW-1:0] RX_LAST   = CNW'(RX_RISES);
  localparam logic [CNW-1:0] RES_FIRST = CNW'(IDLE_CLKS + 1);
  localparam logic [CNW-1:0] END_LAST  = CNW'(1);

  mx_state_e      state_q, state_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic           cs_q, cs_d;
  logic           sclk_q, sclk_d;
  logic           oe_q, oe_d;
  logic           done_q, done_d;
  logic           en;

  // next-state process
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cs_d       = cs_q;
    sclk_d     = sclk_q;
    oe_d       = oe_q;
    done_d     = 1'b0;
    addr_load  = 1'b0;
    addr_shift = 1'b0;
    res_shift  = 1'b0;
    capture    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d   = ST_ADDR;
          cs_d      = 1'b1;
          oe_d      = 1'b1;
          sclk_d    = 1'b0;
          cnt_d     = '0;
          addr_load = 1'b1;
        end
      end
      ST_ADDR: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            cnt_d  = cnt_q + CNW'(1);
          end else begin
            sclk_d = 1'b0;
            if (cnt_q == ADDR_LAST) begin
              cs_d    = 1'b0;
              oe_d    = 1'b0;
              cnt_d   = '0;
              state_d = ST_RECV;
            end else begin
              addr_shift = 1'b1;
            end
          end
        end
      end
      ST_RECV: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            cnt_d  = cnt_q + CNW'(1);
            if (cnt_q >= RES_FIRST) res_shift = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (cnt_q == RX_LAST) begin
              cs_d    = 1'b1;
              cnt_d   = '0;
              state_d = ST_END;
            end
          end
        end
      end
      ST_END: begin
        if (tick) begin
          if (cnt_q == END_LAST) begin
            cs_d    = 1'b0;
            done_d  = 1'b1;
            capture = 1'b1;
            cnt_d   = '0;
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // clock enable: idle waits on requests, busy states advance on ticks
  always_comb en = tick | (state_q == ST_IDLE) | done_q;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cs_q    <= 1'b0;
      sclk_q  <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign run       = (state_q != ST_IDLE);
  assign cs        = cs_q;
  assign sclk      = sclk_q;
  assign oe        = oe_q;
  assign done      = done_q;
endmodule

// File: rtl/mxadc_host.sv
// Host controller for a half-duplex three-wire multiplexed ADC.
module mxadc_host #(
  parameter int HALF_DIV  = 2,
  parameter int IDLE_CLKS = 2,
  parameter int ADDR_BITS = 4,
  parameter int RES_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_BITS-1:0] req_chan,
  output logic                 req_ready,
  output logic                 cs,
  output logic                 sclk,
  output logic                 dat_o,
  output logic                 dat_oe,
  input  logic                 dat_i,
  output logic                 done,
  output logic [RES_BITS-1:0]  result
);
  logic                run, tick;
  logic                addr_load, addr_shift, res_shift, capture;
  logic [RES_BITS-1:0] res_q;
  logic [RES_BITS-1:0] result_q;

  mxadc_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  mxadc_ctrl #(
    .ADDR_BITS (ADDR_BITS),
    .RES_BITS  (RES_BITS),
    .IDLE_CLKS (IDLE_CLKS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .run        (run),
    .cs         (cs),
    .sclk       (sclk),
    .oe         (dat_oe),
    .done       (done),
    .addr_load  (addr_load),
    .addr_shift (addr_shift),
    .res_shift  (res_shift),
    .capture    (capture)
  );

  mxadc_txshift #(.W(ADDR_BITS)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (addr_load),
    .par   (req_chan),
    .shift (addr_shift),
    .msb   (dat_o)
  );

  mxadc_rxshift #(.W(RES_BITS)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (res_shift),
    .sin   (dat_i),
    .q     (res_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result_q <= '0;
    else if (capture) result_q <= res_q;
  end

  assign result = result_q;
endmodule

// File: rtl/mxadc_chk.sv
// Protocol checker bound to the host controller.
module mxadc_chk #(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                cs,
  input logic                sclk,
  input logic                dat_o,
  input logic                dat_oe,
  input logic                done,
  input logic [RES_BITS-1:0] result
);
  assert_drive_steady_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && dat_oe && $past(dat_oe)) |-> $stable(dat_o));

  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cs && !sclk && !dat_oe));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cs && dat_oe && !sclk));

  assert_cs_fall_low_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs) |-> (!sclk && !dat_oe));

  assert_drive_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> cs);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
endmodule

bind mxadc_host mxadc_chk #(.RES_BITS(RES_BITS)) u_chk (.*);

// File: tb/test_mxadc_host.sv
module test_mxadc_host;
  localparam int HD   = 2;
  localparam int IDLE = 3;

  logic        clk, rst_n;
  logic        req_valid;
  logic [3:0]  req_chan;
  logic        req_ready, cs, sclk, dat_o, dat_oe, dat_i, done;
  logic [11:0] result;

  int ntests = 0;
  int nfail  = 0;
  bit finished = 0;

  mxadc_host #(.HALF_DIV(HD), .IDLE_CLKS(IDLE), .ADDR_BITS(4), .RES_BITS(12)) i_mxadc_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_ready(req_ready), .cs(cs), .sclk(sclk), .dat_o(dat_o), .dat_oe(dat_oe),
    .dat_i(dat_i), .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- converter model, evaluated between clock edges
  logic        dev_bit = 1'b1;
  logic [11:0] cur_val = '0;
  logic        cur_null = 1'b0;
  logic [3:0]  addr_sh = '0;
  logic [3:0]  cap_addr = '0;
  logic        ps = 1'b0, pcs = 1'b0, pdo = 1'b0;
  bit          rx = 0, ending = 0;
  int hi_rises = 0, lo_rises = 0, cap_hi = -1, cap_lo = -1;
  int endcnt = 0, end_hi = -1, per = -1, last_rise = -1, cyc = 0;
  int contention = 0, drvviol = 0;

  assign dat_i = dat_oe ? dat_o : dev_bit;

  function automatic logic bit_for(input int k);
    if (k <= IDLE) return 1'b1;
    if (k == IDLE + 1) return cur_null;
    if (k <= IDLE + 13) return cur_val[11 - (k - IDLE - 2)];
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    logic r, f, cr, cf;
    r  = sclk && !ps;
    f  = !sclk && ps;
    cr = cs && !pcs;
    cf = !cs && pcs;
    if (cr) begin
      if (rx) begin cap_lo = lo_rises; ending = 1; endcnt = 1; end
      rx = 0;
      hi_rises = 0;
    end else if (ending && cs) begin
      endcnt++;
    end
    if (cf) begin
      if (ending) begin end_hi = endcnt; ending = 0; end
      else if (hi_rises > 0) begin
        cap_addr = addr_sh; cap_hi = hi_rises; rx = 1; lo_rises = 0;
        dev_bit = bit_for(1);
      end
    end else if (f && rx) begin
      dev_bit = bit_for(lo_rises + 1);
    end
    if (r && cs) begin
      addr_sh = {addr_sh[2:0], dat_i};
      hi_rises++;
      if (hi_rises > 1) per = cyc - last_rise;
    end
    if (r) last_rise = cyc;
    if (r && !cs && rx) lo_rises++;
    if (rx && dat_oe) contention++;
    if (dat_oe && sclk && ps && (dat_o != pdo)) drvviol++;
    ps = sclk; pcs = cs; pdo = dat_o;
    cyc++;
  end

  // ---------------- helpers
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_req(input logic [3:0] ch);
    int n = 0;
    @(negedge clk);
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    req_chan  = ch;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(cs && dat_oe && !sclk, "R3 start cs/oe/sclk", {cs, dat_oe, sclk}, 3'b110);
    chk(dat_o == ch[3], "R3 first bit", dat_o, ch[3]);
  endtask

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); #1; n++; end while (!done && n < 4000);
    chk(done, "R6 done seen", done, 1);
  endtask

  task automatic prep(input logic [11:0] v, input logic nv);
    cur_val = v; cur_null = nv;
    cap_hi = -1; cap_lo = -1; end_hi = -1; per = -1; cap_addr = '0;
  endtask

  // ---------------- scenarios
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_chan = '0;
    repeat (3) @(negedge clk);
    chk(!cs && !sclk && !dat_oe && !done, "R9 outputs in reset",
        {cs, sclk, dat_oe, done}, 0);
    chk(req_ready, "R9 ready in reset", req_ready, 1);
    chk(result == 0, "R9 result in reset", result, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!cs && !sclk && req_ready, "R8 idle lines after reset", {cs, sclk, req_ready}, 1);
  endtask

  task automatic t_exchange(input logic [3:0] ch, input logic [11:0] v, input logic nv);
    int c0, d0;
    prep(v, nv);
    c0 = contention; d0 = drvviol;
    start_req(ch);
    wait_done();
    chk(result == v, "R5 result", result, v);
    chk(cap_addr == ch, "R4 channel word received", cap_addr, ch);
    chk(cap_hi == 4, "R4 rises with cs high", cap_hi, 4);
    chk(cap_lo == IDLE + 13, "R5 rises with cs low", cap_lo, IDLE + 13);
    chk(end_hi == 2 * HD, "R6 end cs high width", end_hi, 2 * HD);
    chk(per == 2 * HD, "R8 sclk period", per, 2 * HD);
    chk(drvviol == d0, "R1 output change while sclk high", drvviol - d0, 0);
    chk(contention == c0, "R5 host drives during receive", contention - c0, 0);
    chk(!cs, "R6 cs low at done", cs, 0);
    @(negedge clk); #1;
    chk(!done, "R6 done one cycle", done, 0);
  endtask

  task automatic t_busy_ignore();
    int highs = 0;
    prep(12'h3C5, 1'b0);
    start_req(4'h6);
    repeat (10) @(negedge clk);
    req_chan = 4'h9; req_valid = 1'b1;
    #1;
    chk(!req_ready, "R2 not ready while busy", req_ready, 0);
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk(cap_addr == 4'h6, "R2 busy request ignored (word)", cap_addr, 6);
    chk(result == 12'h3C5, "R2 result unaffected", result, 12'h3C5);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (cs) highs++;
    end
    chk(highs == 0, "R2 no extra exchange", highs, 0);
    chk(req_ready, "R2 ready after exchange", req_ready, 1);
  endtask

  task automatic t_hold();
    logic [11:0] keep;
    int changes = 0, dones = 0;
    keep = result;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if (result != keep) changes++;
      if (done) dones++;
    end
    chk(changes == 0, "R7 result held", changes, 0);
    chk(dones == 0, "R7 no spurious done", dones, 0);
    chk(!sclk && !cs, "R8 sclk idle low", {sclk, cs}, 0);
  endtask

  // ---------------- main and watchdog
  initial begin
    t_reset();
    t_exchange(4'h0, 12'hFFF, 1'b1);
    t_exchange(4'h7, 12'h000, 1'b1);   // null and junk bits set: must not leak
    t_exchange(4'hA, 12'h5A3, 1'b0);
    t_exchange(4'hF, 12'h800, 1'b1);
    t_exchange(4'h5, 12'h001, 1'b0);
    t_hold();
    t_busy_ignore();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      ntests++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule